// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page number and a set of permission bits after a TLB miss. It first sorts the address into one of three regions by its top bits. Kernel-region addresses are translated directly with no memory traffic. User-region addresses must have canonical upper bits: those bits are all zeros for the code/heap region and all ones for the stack region. An address that is not canonical is rejected at once with an address fault.

For a canonical user address the block walks a three-level table in memory. Each table fills exactly one 8 KB page and holds 1024 entries of 8 bytes. The first table's frame number comes from a base-register input. Each later table's frame comes from the entry read at the level above it. The implemented virtual address is 43 bits wide: three 10-bit indices, highest level first, above a 13-bit page offset.

Reads go through a valid/ready request channel, and the response arrives after a variable delay. The walker keeps at most one read in flight. The result is reported with a single-cycle valid pulse. An entry with its valid bit clear ends the walk and reports a fault code that names the level.

Top module: `ptw_engine`

## Requirements
- R1: After reset, `req_ready` is 1 while `rsp_valid` and `mem_req_valid` are 0.
- R2: Region code `rsp_seg` is 2 (kernel) when address bits 63:62 are `10`. It is 0 (user code/heap) when bit 63 is 0, and 1 (user stack) when bits 63:62 are `11`.
- R3: A user-region address is non-canonical when its bits 63:43 are not all zeros (code/heap) or not all ones (stack). Such an address gives `rsp_fault` = 1 and issues no memory read.
- R4: A kernel-region address gives `rsp_fault` = 0, `rsp_ppn` = address bits 33:13 and `rsp_perm` = `4'b0011`, and issues no memory read.
- R5: The read address at level n (n = 1, 2, 3) is {table frame, index, 3'b000}. The table frame is `base_ppn` for level 1 and the previous entry's frame for later levels. The index is address bits 42:33, 32:23 and 22:13 for levels 1, 2 and 3.
- R6: Entry layout: bit 0 valid; bits 4:1 permissions (bit 1 kernel read, bit 2 kernel write, bit 3 user read, bit 4 user write); bits 52:32 frame number; all other bits ignored. A walk whose three entries are all valid gives `rsp_fault` = 0, `rsp_ppn` = the level-3 frame and `rsp_perm` = level-3 bits 4:1, after exactly three reads.
- R7: An entry at level n with bit 0 clear ends the walk with `rsp_fault` = n + 1 (2, 3 or 4) after exactly n reads.
- R8: At most one read is outstanding. A request that is not yet accepted keeps `mem_req_valid` high and its address unchanged.
- R9: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` is 0 from acceptance until that pulse has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| base_ppn | input | 21 | Frame number of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_seg | output | 2 | Region code (0 code/heap, 1 stack, 2 kernel) |
| rsp_fault | output | 3 | 0 none, 1 address fault, 2..4 invalid entry at level 1..3 |
| rsp_ppn | output | 21 | Physical page number |
| rsp_perm | output | 4 | Permission bits {user write, user read, kernel write, kernel read} |

## Verification
A wrong level counter or a stale table frame shows up on `mem_req_addr` at the very next read. It therefore appears within one memory round trip of the fault, before the result is ever reported. A mistaken region or canonical decision shows up as extra or missing reads and a wrong fault code in the result pulse. For the kernel and address-fault paths, that pulse comes one cycle after acceptance. A state machine that fails to return to idle shows up as `req_ready` staying low, which stalls the next request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        SEG_USER_CODE  = 2'd0,
        SEG_USER_STACK = 2'd1,
        SEG_KERNEL     = 2'd2
    } seg_e;

    localparam logic [2:0] FLT_NONE    = 3'd0;
    localparam logic [2:0] FLT_ADDR    = 3'd1;
    localparam logic [2:0] FLT_PAGE_L1 = 3'd2;

    localparam logic [3:0] PERM_KERNEL_DIRECT = 4'b0011;

endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
    import ptw_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43
) (
    input  logic [VA_W-VA_IMPL-1:0] upper_bits,
    output seg_e                    seg,
    output logic                    canon_fault
);
    // upper_bits holds vaddr[VA_W-1:VA_IMPL]; its top two bits pick the region
    localparam int HI_W = VA_W - VA_IMPL;

    always_comb begin
        canon_fault = 1'b0;
        if (upper_bits[HI_W-1 -: 2] == 2'b10) begin
            seg = SEG_KERNEL;
        end else if (upper_bits[HI_W-1]) begin
            seg         = SEG_USER_STACK;
            canon_fault = ~&upper_bits;
        end else begin
            seg         = SEG_USER_CODE;
            canon_fault = |upper_bits;
        end
    end

endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int IDX_W  = 10,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [IDX_W*LEVELS-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [IDX_W-1:0]        idx
);
    // level 0 uses the most significant index field
    logic [IDX_W-1:0] idx_tbl [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign idx_tbl[l] = vpn[IDX_W*(LEVELS-1-l) +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = idx_tbl[l];
        end
    end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PTE_W   = 64,
    parameter int PPN_W   = 21,
    parameter int PFN_LSB = 32
) (
    input  logic [PTE_W-1:0] pte,
    output logic             valid,
    output logic [3:0]       perm,
    output logic [PPN_W-1:0] pfn
);
    assign valid = pte[0];
    assign perm  = pte[4:1];
    assign pfn   = pte[PFN_LSB +: PPN_W];

endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int OFF_W   = 13,
    parameter int IDX_W   = 10,
    parameter int LEVELS  = 3,
    parameter int PPN_W   = 21,
    parameter int PTE_W   = 64,
    parameter int PFN_LSB = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [PPN_W-1:0]       base_ppn,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [PPN_W+OFF_W-1:0] mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [PTE_W-1:0]       mem_rsp_data,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_seg,
    output logic [2:0]             rsp_fault,
    output logic [PPN_W-1:0]       rsp_ppn,
    output logic [3:0]             rsp_perm
);
    localparam int PA_W     = PPN_W + OFF_W;
    localparam int ENTRY_SH = OFF_W - IDX_W;       // one table per page
    localparam int VPN_W    = VA_IMPL - OFF_W;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int CNT_W    = $clog2(LEVELS + 1) + 1;

    typedef struct packed {
        walk_state_e      state;
        logic [LVL_W-1:0] level;
        logic [VPN_W-1:0] vpn;
        seg_e             seg;
        logic [PPN_W-1:0] table_ppn;
        logic [PPN_W-1:0] res_ppn;
        logic [3:0]       res_perm;
        logic [2:0]       fault;
    } walk_reg_t;

    walk_reg_t walk_d, walk_q;

    seg_e             cls_seg;
    logic             cls_canon_fault;
    logic [IDX_W-1:0] cur_idx;
    logic             pte_valid;
    logic [3:0]       pte_perm;
    logic [PPN_W-1:0] pte_pfn;

    ptw_classify #(.VA_W(VA_W), .VA_IMPL(VA_IMPL)) u_classify (
        .upper_bits (req_vaddr[VA_W-1:VA_IMPL]),
        .seg        (cls_seg),
        .canon_fault(cls_canon_fault)
    );

    ptw_index #(.IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_index (
        .vpn  (walk_q.vpn),
        .level(walk_q.level),
        .idx  (cur_idx)
    );

    ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W), .PFN_LSB(PFN_LSB)) u_decode (
        .pte  (mem_rsp_data),
        .valid(pte_valid),
        .perm (pte_perm),
        .pfn  (pte_pfn)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.vpn       = req_vaddr[VA_IMPL-1:OFF_W];
                    walk_d.seg       = cls_seg;
                    walk_d.level     = '0;
                    walk_d.table_ppn = base_ppn;
                    walk_d.res_ppn   = '0;
                    walk_d.res_perm  = '0;
                    walk_d.fault     = FLT_NONE;
                    if (cls_seg == SEG_KERNEL) begin
                        walk_d.res_ppn  = req_vaddr[PA_W-1:OFF_W];
                        walk_d.res_perm = PERM_KERNEL_DIRECT;
                        walk_d.state    = ST_DONE;
                    end else if (cls_canon_fault) begin
                        walk_d.fault = FLT_ADDR;
                        walk_d.state = ST_DONE;
                    end else begin
                        walk_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) walk_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_valid) begin
                        walk_d.fault = FLT_PAGE_L1 + 3'(walk_q.level);
                        walk_d.state = ST_DONE;
                    end else if (walk_q.level == LVL_W'(LEVELS - 1)) begin
                        walk_d.res_ppn  = pte_pfn;
                        walk_d.res_perm = pte_perm;
                        walk_d.state    = ST_DONE;
                    end else begin
                        walk_d.table_ppn = pte_pfn;
                        walk_d.level     = walk_q.level + 1'b1;
                        walk_d.state     = ST_REQ;
                    end
                end
            end
            ST_DONE: walk_d.state = ST_IDLE;
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q       <= '0;
            walk_q.state <= ST_IDLE;
            walk_q.seg   <= SEG_USER_CODE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.state == ST_IDLE);
    assign mem_req_valid = (walk_q.state == ST_REQ);
    assign mem_req_addr  = {walk_q.table_ppn, cur_idx, ENTRY_SH'(0)};
    assign rsp_valid     = (walk_q.state == ST_DONE);
    assign rsp_seg       = walk_q.seg;
    assign rsp_fault     = walk_q.fault;
    assign rsp_ppn       = walk_q.res_ppn;
    assign rsp_perm      = walk_q.res_perm;

    // checking state: reads issued in the current walk and reads in flight
    logic [CNT_W-1:0] walk_reads_q;
    logic             outstanding_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_reads_q  <= '0;
            outstanding_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) walk_reads_q <= '0;
            else if (mem_req_valid && mem_req_ready) walk_reads_q <= walk_reads_q + 1'b1;
            if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
            else if (mem_rsp_valid) outstanding_q <= 1'b0;
        end
    end

    assert_canon_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ADDR) |-> walk_reads_q == '0);

    assert_kernel_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_seg == SEG_KERNEL) |->
            (walk_reads_q == '0 && rsp_fault == FLT_NONE && rsp_perm == PERM_KERNEL_DIRECT));

    assert_entry_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ENTRY_SH-1:0] == '0);

    assert_full_walk_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE && rsp_seg != SEG_KERNEL) |->
            walk_reads_q == CNT_W'(LEVELS));

    assert_fault_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault >= FLT_PAGE_L1) |->
            walk_reads_q == CNT_W'(rsp_fault - FLT_PAGE_L1 + 3'd1));

    assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding_q);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/ptw_engine_bench.sv
`timescale 1ns/1ps
module ptw_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [20:0] base_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic [1:0]  rsp_seg;
    logic [2:0]  rsp_fault;
    logic [20:0] rsp_ppn;
    logic [3:0]  rsp_perm;

    always #2 clk = ~clk;

    ptw_engine u_ptw_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .base_ppn(base_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_seg(rsp_seg), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
    );

    logic [63:0] pt_mem [bit [33:0]];
    int          errors = 0;
    int          checks = 0;
    int          nreads = 0;
    logic [33:0] obs_addr [3];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory model: random acceptance, 0..3 cycle response delay
    initial begin : responder
        bit          have_pend;
        int          lat;
        logic [33:0] pend_addr;
        have_pend = 0; lat = 0; pend_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (have_pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pt_mem.exists(pend_addr) ? pt_mem[pend_addr] : 64'h0;
                    have_pend     = 0;
                end else lat--;
            end
            mem_req_ready = !have_pend && (($urandom % 3) != 0);
            if (mem_req_valid && mem_req_ready) begin
                if (nreads < 3) obs_addr[nreads] = mem_req_addr;
                nreads++;
                pend_addr = mem_req_addr;
                lat       = $urandom % 4;
                have_pend = 1;
            end
        end
    end

    task automatic build(input logic [63:0] va, input logic [20:0] base, input logic [2:0] vmask);
        logic [20:0] tbl;
        tbl = base;
        pt_mem.delete();
        for (int l = 0; l < 3; l++) begin
            logic [9:0]  idx;
            logic [20:0] nxt;
            logic [33:0] a;
            idx = va[(42 - 10*l) -: 10];
            a   = {tbl, idx, 3'b000};
            nxt = 21'($urandom);
            pt_mem[a] = {11'h0, nxt, 27'($urandom), 4'($urandom), vmask[l]};
            tbl = nxt;
        end
    endtask

    task automatic model(input logic [63:0] va, input logic [20:0] base,
                         output logic [1:0] seg, output logic [2:0] fault,
                         output logic [20:0] ppn, output logic [3:0] perm,
                         output int n, output logic [33:0] addrs [3]);
        logic [20:0] hi;
        logic [20:0] tbl;
        bit          stop;
        hi = va[63:43]; ppn = '0; perm = '0; n = 0; fault = 3'd0; stop = 0;
        for (int i = 0; i < 3; i++) addrs[i] = '0;
        if (va[63:62] == 2'b10) begin
            seg = 2'd2; ppn = va[33:13]; perm = 4'b0011;
        end else begin
            seg = va[63] ? 2'd1 : 2'd0;
            if (!(hi == '0 || hi == '1)) fault = 3'd1;
            else begin
                tbl = base;
                for (int l = 0; l < 3; l++) begin
                    if (!stop) begin
                        logic [63:0] pte;
                        logic [33:0] a;
                        a = {tbl, va[(42 - 10*l) -: 10], 3'b000};
                        addrs[l] = a; n++;
                        pte = pt_mem.exists(a) ? pt_mem[a] : 64'h0;
                        if (!pte[0]) begin
                            fault = 3'(2 + l); stop = 1;
                        end else begin
                            tbl = pte[52:32];
                            if (l == 2) begin ppn = tbl; perm = pte[4:1]; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input logic [20:0] base);
        logic [1:0]  e_seg;
        logic [2:0]  e_fault;
        logic [20:0] e_ppn;
        logic [3:0]  e_perm;
        int          e_n;
        logic [33:0] e_addr [3];
        int          t;
        string       tag;
        model(va, base, e_seg, e_fault, e_ppn, e_perm, e_n, e_addr);
        if (e_fault == 3'd1) tag = "R3";
        else if (e_seg == 2'd2) tag = "R4";
        else if (e_fault == 3'd0) tag = "R6";
        else tag = "R7";
        @(negedge clk);
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        base_ppn = base; req_vaddr = va; req_valid = 1'b1; nreads = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9", "ready low while busy", 64'(req_ready), 64'd0);
        t = 0;
        while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
        chk(rsp_valid, tag, "result arrived", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == e_fault, tag, "fault code", 64'(rsp_fault), 64'(e_fault));
        if (e_fault != 3'd1)
            chk(rsp_seg == e_seg, "R2", "region code", 64'(rsp_seg), 64'(e_seg));
        if (e_fault == 3'd0) begin
            chk(rsp_ppn == e_ppn, tag, "page number", 64'(rsp_ppn), 64'(e_ppn));
            chk(rsp_perm == e_perm, tag, "permissions", 64'(rsp_perm), 64'(e_perm));
        end
        chk(nreads == e_n, tag, "read count", 64'(nreads), 64'(e_n));
        for (int i = 0; i < 3; i++)
            if (i < e_n && i < nreads)
                chk(obs_addr[i] == e_addr[i], "R5", "entry address", 64'(obs_addr[i]), 64'(e_addr[i]));
        @(negedge clk);
        chk(!rsp_valid, "R9", "result is one pulse", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [63:0] rand_va();
        logic [63:0] va;
        int          kind;
        va   = {$urandom, $urandom};
        kind = $urandom % 10;
        if (kind < 2) va[63:62] = 2'b10;
        else if (kind < 4) va[63:43] = va[63:43];
        else if (kind < 7) va[63:43] = '0;
        else va[63:43] = '1;
        return va;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [63:0] va;
        logic [20:0] base;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(!rsp_valid, "R1", "no result after reset", 64'(rsp_valid), 64'd0);
        chk(!mem_req_valid, "R1", "no read after reset", 64'(mem_req_valid), 64'd0);

        // R4 kernel region, direct mapping
        run_walk(64'h8000_0003_FFFF_E123, 21'h1);
        // R3 code/heap with a stray upper bit, stack with one upper bit clear
        run_walk(64'h0004_0000_0000_1000, 21'h2);
        run_walk(64'hFFFF_F7FF_FFFF_0000, 21'h2);
        // R6 full walks in both user regions
        va = 64'h0000_0123_4567_8ABC; base = 21'h0ABCD;
        build(va, base, 3'b111); run_walk(va, base);
        va = 64'hFFFF_FFAB_CDEF_0123; base = 21'h1FFFF;
        build(va, base, 3'b111); run_walk(va, base);
        // R7 invalid entry at each level
        va = 64'h0000_0555_AAAA_5555; base = 21'h00042;
        build(va, base, 3'b110); run_walk(va, base);
        build(va, base, 3'b101); run_walk(va, base);
        build(va, base, 3'b011); run_walk(va, base);

        for (int k = 0; k < 300; k++) begin
            va   = rand_va();
            base = 21'($urandom);
            build(va, base, {($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0});
            run_walk(va, base);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule